// File: doc/BRIEF.md
# Fetch Redirect Controller

This block steers the prefetch address of a short in-order pipeline that has an operand stage followed by an execute stage. Each cycle it receives the decoded control-flow class of the instruction in the operand stage, together with that instruction's address and immediate. It also receives a cancel flag for the instruction in execute and the register value forwarded from execute. From these it decides whether the fetch address jumps, where it jumps to, and in which cycle. The redirect strobe also serves as the flush request for younger instructions that were already fetched.

The block never redirects before the operand stage, because it does no speculation. A PC-relative branch normally redirects while it is in the operand stage. When it sits directly behind an unresolved skip, it is instead carried into execute and acts there, unless the skip cancels it. A register-indirect jump or call redirects in execute, using the value forwarded in that same cycle. A trap forms its vector-entry address in execute, issues a data-memory read, and holds the pipeline stalled until the vector word returns. The vector word is the new fetch address. Subroutine branches and calls deliver their return address for the link register in the cycle of the redirect.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_pc` is loaded with `RESET_VEC` (0x0100 by default) and any trap wait is cleared. After that edge, `stall`, `redirect` and `dmem_req` are low until new stimulus arrives.
- R2: In a cycle with neither `redirect` nor `stall`, `fetch_pc` advances by the instruction size (1<<`ILOG` = 2 bytes by default) at the next edge. A redirect loads `fetch_pc` with `redirect_pc` at the next edge.
- R3: The control-flow class is encoded on `op_kind` as 0 none, 1 relative branch, 2 relative branch-to-subroutine, 3 register jump, 4 register call, 5 trap. A valid class 1 or 2 with `op_after_skip` low raises `redirect` in that same cycle. Its target is `op_pc + (sign-extended op_offset << ILOG)`, modulo 2^AW.
- R4: A class 1 or 2 with `op_after_skip` high gives no redirect in the operand cycle. In the next cycle, when it is in execute, it redirects to the same relative target, unless `ex_cancel` is high in that cycle, in which case it has no effect.
- R5: A class 3 or 4 redirects one cycle after its operand cycle, to the value present on `ex_reg_val` in that execute cycle. It does nothing if `ex_cancel` is high in that cycle.
- R6: A trap (class 5) raises `dmem_req` for one cycle when it is in execute. `dmem_addr` is `VEC_BASE + (op_offset[TCW-1:0] << VLOG)`. `stall` is high from that cycle until the cycle in which `dmem_rvalid` arrives. A cancelled trap makes no request and no stall.
- R7: In the cycle `dmem_rvalid` arrives for a waiting trap, `redirect` is high with `redirect_pc = dmem_rdata` and `stall` is low. While the trap waits, `fetch_pc` is held and no new request is made.
- R8: `link_we` is high, with `link_data` equal to the instruction's own address plus the instruction size, exactly in the redirect cycle of a class 2 or class 4 instruction. It is never high otherwise.
- R9: When an execute-stage redirect coincides with a relative branch in the operand stage, the execute target wins. The operand-stage instruction is flushed and never redirects later.
- R10: While `stall` is high, a control-flow instruction in the operand stage causes no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operand stage holds a valid instruction |
| op_kind | input | 3 | Control-flow class of the operand-stage instruction |
| op_pc | input | AW | Address of the operand-stage instruction |
| op_offset | input | OFFW | Relative offset in words, or trap number in the low TCW bits |
| op_after_skip | input | 1 | An unresolved skip directly precedes this instruction |
| ex_cancel | input | 1 | The instruction now in execute was skipped |
| ex_reg_val | input | AW | Register target forwarded from execute in this cycle |
| dmem_req | output | 1 | Read request for the trap vector entry |
| dmem_addr | output | AW | Vector entry address |
| dmem_rvalid | input | 1 | Vector word returned |
| dmem_rdata | input | AW | Returned vector word |
| fetch_pc | output | AW | Prefetch program counter |
| redirect | output | 1 | Fetch redirect and flush of younger instructions |
| redirect_pc | output | AW | New fetch address, valid with redirect |
| stall | output | 1 | Freeze the operand and execute stages |
| link_we | output | 1 | Write the return address to the link register |
| link_data | output | AW | Return address |

## Verification
The hardest cases to reach are collisions between stages. One is an execute-stage redirect that lands in the same cycle as a fresh relative branch in the operand stage. The other is a trap wait during which the operand stage keeps presenting a branch. The stimulus forces both. Each jump and call is followed immediately by a branch in the operand stage, and every trap wait presents a branch on each waiting cycle. The latency before `dmem_rvalid` is varied with the trap number. A skip-deferred branch is swept over both outcomes of `ex_cancel`. Reset is asserted in the middle of a trap wait.

// File: rtl/frc_pkg.sv
`timescale 1ns/1ps
// Shared types of the fetch redirect controller.
package frc_pkg;
    // Control-flow class as delivered by decode; values are part of the port contract.
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_BR   = 3'd1,
        K_BSR  = 3'd2,
        K_JMP  = 3'd3,
        K_CALL = 3'd4,
        K_TRAP = 3'd5
    } cf_kind_e;
endpackage

// File: rtl/frc_rel_target.sv
`timescale 1ns/1ps
// Computes the PC-relative target and the return address of an instruction.
// Assumes AW > OFFW; the offset counts instruction words of 2**ILOG bytes.
module frc_rel_target #(
    parameter int AW   = 16,
    parameter int OFFW = 8,
    parameter int ILOG = 1
) (
    input  logic [AW-1:0]   pc,
    input  logic [OFFW-1:0] offset,
    output logic [AW-1:0]   target,
    output logic [AW-1:0]   ret_addr
);
    localparam logic [AW-1:0] STEP = AW'(1) << ILOG;

    logic [AW-1:0] offset_sx;

    // Sign-extend, scale and add the offset.
    always_comb begin
        offset_sx = {{(AW-OFFW){offset[OFFW-1]}}, offset};
        target    = pc + (offset_sx << ILOG);
        ret_addr  = pc + STEP;
    end
endmodule

// File: rtl/frc_exec.sv
`timescale 1ns/1ps
// Execute-stage slot of the redirect controller: holds the instruction that
// left the operand stage, resolves deferred branches and register targets,
// and runs the trap vector read. Assumes the vector word arrives at least
// one cycle after the request.
module frc_exec
    import frc_pkg::*;
#(
    parameter int              AW    = 16,
    parameter int              TCW   = 4,
    parameter int              VLOG  = 1,
    parameter int              ILOG  = 1,
    parameter logic [AW-1:0]   VBASE = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          op_valid,
    input  logic [2:0]    op_kind,
    input  logic [AW-1:0] op_pc,
    input  logic [AW-1:0] op_rel_tgt,
    input  logic          op_defer,
    input  logic [TCW-1:0] op_code,
    input  logic          ex_cancel,
    input  logic [AW-1:0] ex_reg_val,
    input  logic          dmem_rvalid,
    input  logic [AW-1:0] dmem_rdata,
    output logic          dmem_req,
    output logic [AW-1:0] dmem_addr,
    output logic          ex_redir,
    output logic [AW-1:0] ex_tgt,
    output logic          ex_link,
    output logic [AW-1:0] ex_ret,
    output logic          stall
);
    localparam logic [AW-1:0] STEP = AW'(1) << ILOG;

    logic           x_valid;
    cf_kind_e       x_kind;
    logic [AW-1:0]  x_pc;
    logic [AW-1:0]  x_rel;
    logic           x_defer;
    logic [TCW-1:0] x_code;
    logic           wait_q;
    logic           live;
    logic           trap_fire;

    // Slot register: flushed on redirect, frozen on stall, else loaded from operand stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_valid <= 1'b0;
            x_kind  <= K_NONE;
            x_pc    <= '0;
            x_rel   <= '0;
            x_defer <= 1'b0;
            x_code  <= '0;
        end else if (flush) begin
            x_valid <= 1'b0;
        end else if (!stall) begin
            x_valid <= op_valid;
            x_kind  <= cf_kind_e'(op_kind);
            x_pc    <= op_pc;
            x_rel   <= op_rel_tgt;
            x_defer <= op_defer;
            x_code  <= op_code;
        end
    end

    // Trap wait state: set by the request, cleared by the response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= 1'b0;
        else if (trap_fire)
            wait_q <= 1'b1;
        else if (wait_q && dmem_rvalid)
            wait_q <= 1'b0;
    end

    // Resolve the execute-stage action of the slot.
    always_comb begin
        live      = x_valid && !ex_cancel && !wait_q;
        trap_fire = live && (x_kind == K_TRAP);
        dmem_req  = trap_fire;
        dmem_addr = VBASE + ({{(AW-TCW){1'b0}}, x_code} << VLOG);
        stall     = trap_fire || (wait_q && !dmem_rvalid);
        ex_ret    = x_pc + STEP;
        ex_redir  = 1'b0;
        ex_tgt    = x_rel;
        ex_link   = 1'b0;
        if (wait_q && dmem_rvalid) begin
            ex_redir = 1'b1;
            ex_tgt   = dmem_rdata;
        end else if (live && x_defer && (x_kind == K_BR || x_kind == K_BSR)) begin
            ex_redir = 1'b1;
            ex_link  = (x_kind == K_BSR);
        end else if (live && (x_kind == K_JMP || x_kind == K_CALL)) begin
            ex_redir = 1'b1;
            ex_tgt   = ex_reg_val;
            ex_link  = (x_kind == K_CALL);
        end
    end

    // R6: a request is always followed by a stall or the trap redirect.
    p_req_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req |=> (stall || ex_redir));
    // R7: no second request while the vector read is outstanding.
    p_single_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req |=> !dmem_req);
endmodule

// File: rtl/frc_fetch_ctr.sv
`timescale 1ns/1ps
// Prefetch program counter: loads the redirect target, holds on stall and
// otherwise steps by one instruction.
module frc_fetch_ctr #(
    parameter int            AW   = 16,
    parameter int            ILOG = 1,
    parameter logic [AW-1:0] RVEC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    input  logic          stall,
    output logic [AW-1:0] pc_q
);
    localparam logic [AW-1:0] STEP = AW'(1) << ILOG;

    // Counter update with redirect taking priority over stall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RVEC;
        else if (redirect)
            pc_q <= target;
        else if (!stall)
            pc_q <= pc_q + STEP;
    end

    // R2: idle cycles step the counter by one instruction.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !stall) |=> (pc_q == $past(pc_q) + STEP));
    // R7: a stall holds the counter.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect) |=> $stable(pc_q));
endmodule

// File: rtl/fetch_redirect_ctrl.sv
`timescale 1ns/1ps
// Fetch redirect controller top: picks between the operand-stage relative
// redirect and the execute-stage redirect, and drives the prefetch counter.
// Assumes decode supplies op_kind per frc_pkg::cf_kind_e and clears
// op_valid for instructions flushed by a redirect.
module fetch_redirect_ctrl
    import frc_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            OFFW      = 8,
    parameter int            ILOG      = 1,
    parameter int            TCW       = 4,
    parameter int            VLOG      = 1,
    parameter logic [AW-1:0] VEC_BASE  = 16'h0040,
    parameter logic [AW-1:0] RESET_VEC = 16'h0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_kind,
    input  logic [AW-1:0]   op_pc,
    input  logic [OFFW-1:0] op_offset,
    input  logic            op_after_skip,
    input  logic            ex_cancel,
    input  logic [AW-1:0]   ex_reg_val,
    output logic            dmem_req,
    output logic [AW-1:0]   dmem_addr,
    input  logic            dmem_rvalid,
    input  logic [AW-1:0]   dmem_rdata,
    output logic [AW-1:0]   fetch_pc,
    output logic            redirect,
    output logic [AW-1:0]   redirect_pc,
    output logic            stall,
    output logic            link_we,
    output logic [AW-1:0]   link_data
);
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] rel_ret;
    logic          op_rel;
    logic          op_defer;
    logic          op_hit;
    logic          ex_redir;
    logic [AW-1:0] ex_tgt;
    logic          ex_link;
    logic [AW-1:0] ex_ret;

    frc_rel_target #(.AW(AW), .OFFW(OFFW), .ILOG(ILOG)) u_rel (
        .pc(op_pc), .offset(op_offset), .target(rel_tgt), .ret_addr(rel_ret)
    );

    // Operand-stage decision: relative branch not behind a skip, pipeline free.
    always_comb begin
        op_rel   = op_valid && (op_kind == K_BR || op_kind == K_BSR);
        op_defer = op_rel && op_after_skip;
        op_hit   = op_rel && !op_after_skip && !stall && !ex_redir;
    end

    frc_exec #(.AW(AW), .TCW(TCW), .VLOG(VLOG), .ILOG(ILOG), .VBASE(VEC_BASE)) u_ex (
        .clk(clk), .rst_n(rst_n), .flush(redirect),
        .op_valid(op_valid), .op_kind(op_kind), .op_pc(op_pc),
        .op_rel_tgt(rel_tgt), .op_defer(op_defer), .op_code(op_offset[TCW-1:0]),
        .ex_cancel(ex_cancel), .ex_reg_val(ex_reg_val),
        .dmem_rvalid(dmem_rvalid), .dmem_rdata(dmem_rdata),
        .dmem_req(dmem_req), .dmem_addr(dmem_addr),
        .ex_redir(ex_redir), .ex_tgt(ex_tgt), .ex_link(ex_link), .ex_ret(ex_ret),
        .stall(stall)
    );

    // Merge the two redirect sources, execute first.
    always_comb begin
        redirect    = ex_redir || op_hit;
        redirect_pc = ex_redir ? ex_tgt : rel_tgt;
        link_we     = ex_redir ? ex_link : (op_hit && op_kind == K_BSR);
        link_data   = ex_redir ? ex_ret : rel_ret;
    end

    frc_fetch_ctr #(.AW(AW), .ILOG(ILOG), .RVEC(RESET_VEC)) u_pc (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .target(redirect_pc),
        .stall(stall), .pc_q(fetch_pc)
    );

    // R2: a redirect lands in the prefetch counter at the next edge.
    p_redirect_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_pc == $past(redirect_pc)));
    // R8: the link write only accompanies a redirect.
    p_link_with_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> redirect);
    // R10: stall and redirect never coincide.
    p_no_redirect_in_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !redirect);
    // R9: an execute redirect is followed by a cycle free of operand leftovers.
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_redir && !op_valid) |=> !ex_redir);
endmodule

// File: tb/fetch_redirect_ctrl_test.sv
`timescale 1ns/1ps
module fetch_redirect_ctrl_test;
    localparam int AW = 16;
    localparam logic [15:0] RVEC  = 16'h0100;
    localparam logic [15:0] VBASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [15:0] op_pc = '0;
    logic [7:0]  op_offset = '0;
    logic        op_after_skip = 1'b0;
    logic        ex_cancel = 1'b0;
    logic [15:0] ex_reg_val = '0;
    logic        dmem_req;
    logic [15:0] dmem_addr;
    logic        dmem_rvalid = 1'b0;
    logic [15:0] dmem_rdata = '0;
    logic [15:0] fetch_pc;
    logic        redirect;
    logic [15:0] redirect_pc;
    logic        stall;
    logic        link_we;
    logic [15:0] link_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    fetch_redirect_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_pc(op_pc), .op_offset(op_offset), .op_after_skip(op_after_skip),
        .ex_cancel(ex_cancel), .ex_reg_val(ex_reg_val),
        .dmem_req(dmem_req), .dmem_addr(dmem_addr),
        .dmem_rvalid(dmem_rvalid), .dmem_rdata(dmem_rdata),
        .fetch_pc(fetch_pc), .redirect(redirect), .redirect_pc(redirect_pc),
        .stall(stall), .link_we(link_we), .link_data(link_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rel(input logic [15:0] pc, input logic [7:0] off);
        return pc + ({{8{off[7]}}, off} << 1);
    endfunction

    // Next cycle: clear inputs at negedge, settle.
    task automatic tick_idle();
        @(negedge clk);
        op_valid = 0; op_kind = 0; op_after_skip = 0; ex_cancel = 0; dmem_rvalid = 0;
        #1;
    endtask

    task automatic tick_op(input logic [2:0] k, input logic [15:0] pc, input logic [7:0] off, input bit skp);
        @(negedge clk);
        op_valid = 1; op_kind = k; op_pc = pc; op_offset = off; op_after_skip = skp;
        ex_cancel = 0; dmem_rvalid = 0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] tgt;
        // R1: reset state
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        chk(fetch_pc == RVEC, "R1 fetch_pc", fetch_pc, RVEC);
        chk(!stall && !redirect && !dmem_req, "R1 quiet", {stall, redirect, dmem_req}, 0);

        // R2: sequential stepping
        for (int i = 0; i < 4; i++) begin
            prev = fetch_pc;
            tick_idle();
            chk(fetch_pc == prev + 16'd2, "R2 step", fetch_pc, prev + 16'd2);
        end

        // R3/R8: relative branch sweep in operand stage
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 256; o++) begin
                logic [15:0] pc;
                logic [2:0] k;
                pc = (p == 0) ? 16'h0200 : (p == 1) ? 16'hFFF0 : 16'h0004;
                k = o[0] ? 3'd2 : 3'd1;
                tgt = rel(pc, o[7:0]);
                tick_op(k, pc, o[7:0], 0);
                chk(redirect && redirect_pc == tgt, "R3 target", redirect_pc, tgt);
                chk(link_we == (k == 3'd2), "R8 link_we", link_we, k == 3'd2);
                if (k == 3'd2)
                    chk(link_data == pc + 16'd2, "R8 link_data", link_data, pc + 16'd2);
                tick_idle();
                chk(fetch_pc == tgt, "R2 load", fetch_pc, tgt);
                chk(!redirect, "R3 single", redirect, 0);
            end
        end

        // R4: branch behind an unresolved skip
        for (int o = 0; o < 16; o++) begin
            logic [15:0] pc;
            bit c;
            logic [2:0] k;
            pc = 16'h1000 + 16'(o * 6);
            c = o[0];
            k = o[1] ? 3'd2 : 3'd1;
            tgt = rel(pc, 8'(o * 17 - 100));
            tick_op(k, pc, 8'(o * 17 - 100), 1);
            chk(!redirect, "R4 no early redirect", redirect, 0);
            @(negedge clk);
            op_valid = 0; op_after_skip = 0; ex_cancel = c; #1;
            chk(redirect == !c, "R4 execute redirect", redirect, !c);
            if (!c) begin
                chk(redirect_pc == tgt, "R4 target", redirect_pc, tgt);
                chk(link_we == (k == 3'd2), "R8 deferred link", link_we, k == 3'd2);
                if (k == 3'd2)
                    chk(link_data == pc + 16'd2, "R8 deferred link_data", link_data, pc + 16'd2);
            end else begin
                chk(!link_we, "R8 cancelled link", link_we, 0);
            end
            tick_idle();
            chk(!redirect, "R4 once", redirect, 0);
        end

        // R5/R9: register jumps and calls colliding with an operand branch
        for (int v = 0; v < 24; v++) begin
            logic [15:0] pc;
            logic [2:0] k;
            bit c;
            pc = 16'h2000 + 16'(v * 10);
            k = v[0] ? 3'd4 : 3'd3;
            c = (v % 3 == 2);
            tick_op(k, pc, 8'h00, 0);
            chk(!redirect, "R5 no operand redirect", redirect, 0);
            @(negedge clk);
            ex_reg_val = 16'hA000 ^ 16'(v * 4099);
            ex_cancel = c;
            op_valid = !c; op_kind = 3'd1; op_pc = 16'h3000; op_offset = 8'd5; op_after_skip = 0;
            #1;
            if (c) begin
                chk(!redirect, "R5 cancelled", redirect, 0);
            end else begin
                chk(redirect && redirect_pc == ex_reg_val, "R9 execute wins", redirect_pc, ex_reg_val);
                chk(link_we == (k == 3'd4), "R8 call link", link_we, k == 3'd4);
                if (k == 3'd4)
                    chk(link_data == pc + 16'd2, "R8 call link_data", link_data, pc + 16'd2);
                tgt = ex_reg_val;
                tick_idle();
                chk(!redirect, "R9 flushed branch silent", redirect, 0);
                chk(fetch_pc == tgt, "R5 fetch_pc", fetch_pc, tgt);
            end
            tick_idle();
        end

        // R6/R7/R10: traps with varying response latency
        for (int code = 0; code < 16; code++) begin
            int lat;
            lat = code % 4;
            tick_op(3'd5, 16'h4000, 8'(code), 0);
            chk(!redirect && !stall, "R6 operand quiet", {redirect, stall}, 0);
            @(negedge clk);
            op_valid = 1; op_kind = 3'd1; op_pc = 16'h5000; op_offset = 8'd9; #1;
            chk(dmem_req, "R6 req", dmem_req, 1);
            chk(dmem_addr == VBASE + 16'(code * 2), "R6 addr", dmem_addr, VBASE + 16'(code * 2));
            chk(stall && !redirect, "R10 stalled branch", {stall, redirect}, 2'b10);
            prev = fetch_pc;
            for (int w = 0; w < lat; w++) begin
                @(negedge clk); #1;
                chk(stall && !dmem_req && !redirect, "R7 waiting", {stall, dmem_req, redirect}, 3'b100);
                chk(fetch_pc == prev, "R7 hold", fetch_pc, prev);
            end
            @(negedge clk);
            op_valid = 0; dmem_rvalid = 1; dmem_rdata = 16'h6000 + 16'(code * 34); #1;
            chk(redirect && redirect_pc == dmem_rdata, "R7 vector", redirect_pc, dmem_rdata);
            chk(!stall && !link_we, "R7 release", {stall, link_we}, 0);
            tgt = dmem_rdata;
            tick_idle();
            chk(fetch_pc == tgt && !redirect, "R7 fetch_pc", fetch_pc, tgt);
        end

        // R6: cancelled trap
        tick_op(3'd5, 16'h4000, 8'd3, 0);
        @(negedge clk); op_valid = 0; ex_cancel = 1; #1;
        chk(!dmem_req && !stall, "R6 cancelled trap", {dmem_req, stall}, 0);
        tick_idle();

        // R1: reset in the middle of a trap wait
        tick_op(3'd5, 16'h4000, 8'd7, 0);
        tick_idle();
        chk(stall, "R6 wait before reset", stall, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        chk(!stall && !dmem_req && !redirect, "R1 wait cleared", {stall, dmem_req, redirect}, 0);
        chk(fetch_pc == RVEC, "R1 vector", fetch_pc, RVEC);
        @(negedge clk); dmem_rvalid = 1; dmem_rdata = 16'h7777; #1;
        chk(!redirect, "R1 stale response ignored", redirect, 0);
        tick_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule